// File: doc/BRIEF.md
# SDRAM Bank Timing and Legality Tracker

This block sits beside a DRAM command scheduler and keeps, for every internal bank of a multi-bank SDRAM, the state that decides which commands are legal right now. Each bank is either closed (precharged, no row held), opening (row activation in progress), open (one row held in the row buffer) or closing (precharge in progress). From that state the tracker publishes, every cycle, one ready flag per bank for row activation, for precharge and for column access, the row each bank holds, and whether the shared data bus can take write data this cycle.

The scheduler presents at most one command per cycle, since bank, row and column addresses share one set of address lines. The tracker checks that command against bank state, the open row and the data-bus rules. A legal command updates the state at the next clock edge. An illegal one raises the error flag in the same cycle and leaves every piece of state as it was. Read data reaches the bus a fixed number of cycles after issue. Write data is on the bus in the issue cycle. A direction change on the bus needs one empty cycle between the two transfers.

Top module: `bank_timing_tracker`

## Requirements
- R1: After reset every bank is closed: all activate-ready flags are 1, all precharge-ready and column-ready flags are 0, every reported open row is 0, the write-bus flag is 1 and the error flag is 0.
- R2: An activate (op code 1) is legal only to a closed bank. An activate accepted in cycle c loads the reported row at once. The bank then accepts no command in cycles c+1 and c+2 and becomes open, ready for column access and precharge, in cycle c+T_ACT (default 3).
- R3: A precharge (op code 2) is legal only to an open bank. A precharge accepted in cycle c leaves the bank busy until it is closed and activate-ready again in cycle c+T_PRE (default 3). A precharge to a closed or busy bank is an error.
- R4: A bank that is opening or closing does not block commands to any other bank.
- R5: Column reads (op code 3) and writes (op code 4) are legal only to an open bank, and only when the command's row equals that bank's open row. They may be issued on consecutive cycles. A column access leaves the bank open with its row unchanged.
- R6: Read data occupies the data bus RD_LAT cycles (default 3) after issue, and write data occupies it in the issue cycle. A write is therefore illegal in any cycle in which a read was issued 2, 3 or 4 cycles earlier (collision or missing turnaround cycle), and the write-bus flag is 0 in exactly those cycles. Reads are never held back by the bus.
- R7: A column read or write with auto-precharge (op codes 5 and 6) follows the rules of R5 and R6. When accepted in cycle c, it makes the bank busy in cycles c+1 to c+3, so the bank is activate-ready in cycle c+4.
- R8: An illegal command raises cmd_err in the cycle it is presented, combinationally, and changes no bank state, no reported row and no bus history.
- R9: Op code 0 is a no-operation and op code 7 is reserved and always illegal. While cmd_valid is 0 the op code, bank and row inputs have no effect and cmd_err stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 3 | Op code: 0 nop, 1 activate, 2 precharge, 3 read, 4 write, 5 read with auto-precharge, 6 write with auto-precharge, 7 reserved |
| cmd_bank | input | BANK_W (2) | Target bank |
| cmd_row | input | ROW_W (12) | Row to open (activate) or row the column access expects |
| act_rdy | output | NUM_BANKS (4) | Per bank: an activate would be legal |
| pre_rdy | output | NUM_BANKS (4) | Per bank: a precharge would be legal |
| col_rdy | output | NUM_BANKS (4) | Per bank: a column access to its open row would be legal (bus rules apart) |
| open_row | output | NUM_BANKS*ROW_W (48) | Row held by each bank, bank b in bits [b*ROW_W +: ROW_W] |
| wr_bus_ok | output | 1 | The data bus can take write data this cycle |
| cmd_err | output | 1 | The presented command is illegal and is dropped |

## Verification
The bench builds the block with 4 banks and only 16 rows, keeping the default 3-cycle activate, precharge and read latencies. With only 16 rows, the long pseudo-random phase often sends column accesses that hit an open row, sends many that miss it, and puts reads close enough together for the collision and turnaround windows on the write side. The four banks let the bench overlap an activate or a precharge in one bank with legal traffic to the others. The 3-cycle timings make each busy window and each boundary cycle (c+3 after activate or precharge, c+4 after auto-precharge, writes 2 to 4 cycles after a read) reachable with directed commands.

// File: rtl/btt_pkg.sv
// Package btt_pkg
// Shared command and bank-state encodings for the bank timing tracker.
// Assumes the command op code is three bits wide, as decoded by the top.
package btt_pkg;

    typedef enum logic [2:0] {
        OP_NOP = 3'd0,
        OP_ACT = 3'd1,
        OP_PRE = 3'd2,
        OP_RD  = 3'd3,
        OP_WR  = 3'd4,
        OP_RDA = 3'd5,
        OP_WRA = 3'd6,
        OP_RSV = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        BK_CLOSED,
        BK_OPENING,
        BK_OPEN,
        BK_CLOSING
    } bank_st_e;

endpackage

// File: rtl/btt_bank.sv
// Module btt_bank
// State of one internal DRAM bank: closed, opening, open or closing, with a
// down-counter for the busy window and the row held in the row buffer.
// Assumes the go strobes are only raised for commands already found legal,
// and at most one of them per cycle. T_ACT and T_PRE must be at least 2.
module btt_bank #(
    parameter int ROW_W = 12,
    parameter int T_ACT = 3,
    parameter int T_PRE = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_go,
    input  logic             pre_go,
    input  logic             col_go,
    input  logic             col_ap,
    input  logic [ROW_W-1:0] row_in,
    output logic             is_closed,
    output logic             is_open,
    output logic [ROW_W-1:0] row_q
);
    import btt_pkg::*;

    localparam int T_MAX = (T_ACT > T_PRE + 1) ? T_ACT : T_PRE + 1;
    localparam int CNT_W = $clog2(T_MAX + 1);

    bank_st_e         state;
    logic [CNT_W-1:0] busy_cnt;

    // Advance the bank state on accepted commands and busy-window expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= BK_CLOSED;
            busy_cnt <= '0;
            row_q    <= '0;
        end else if (act_go) begin
            state    <= BK_OPENING;
            busy_cnt <= CNT_W'(T_ACT - 1);
            row_q    <= row_in;
        end else if (pre_go) begin
            state    <= BK_CLOSING;
            busy_cnt <= CNT_W'(T_PRE - 1);
        end else if (col_go && col_ap) begin
            state    <= BK_CLOSING;
            busy_cnt <= CNT_W'(T_PRE);
        end else if (state == BK_OPENING || state == BK_CLOSING) begin
            busy_cnt <= busy_cnt - 1'b1;
            if (busy_cnt == CNT_W'(1)) begin
                state <= (state == BK_OPENING) ? BK_OPEN : BK_CLOSED;
            end
        end
    end

    // Publish the two stable states; busy states report neither.
    always_comb begin
        is_closed = (state == BK_CLOSED);
        is_open   = (state == BK_OPEN);
    end

    assert_act_from_closed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        act_go |-> is_closed);
    assert_act_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        act_go |=> (!is_closed && !is_open));
    assert_pre_from_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pre_go |-> is_open);
    assert_pre_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pre_go |=> (!is_closed && !is_open));
    assert_col_on_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
        col_go |-> is_open);
    assert_row_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        is_open |=> $stable(row_q));
    assert_ap_closes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (col_go && col_ap) |=> (!is_closed && !is_open));
    assert_single_go_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({act_go, pre_go, col_go}));

endmodule

// File: rtl/btt_dq_window.sv
// Module btt_dq_window
// Data-bus occupancy for writes. Keeps a short history of issued reads and
// clears the write flag when the write data would collide with read data or
// sit next to it without a turnaround cycle.
// Assumes RD_LAT >= 2 and that a write is only issued when wr_free is 1.
module btt_dq_window #(
    parameter int RD_LAT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_go,
    output logic wr_free
);
    localparam int HIST_W = RD_LAT + 1;

    // Bit i set: a read was issued i+1 cycles ago.
    logic [HIST_W-1:0] rd_hist;

    // Shift the read history by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_hist <= '0;
        end else begin
            rd_hist <= {rd_hist[HIST_W-2:0], rd_go};
        end
    end

    // Write data must avoid read data one cycle before, at, and one cycle after.
    always_comb begin
        wr_free = ~|rd_hist[RD_LAT:RD_LAT-2];
    end

    assert_rd_blocks_wr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_go |-> ##2 !wr_free);

endmodule

// File: rtl/bank_timing_tracker.sv
// Module bank_timing_tracker
// Tracks every internal bank of a multi-bank SDRAM and judges the single
// command presented each cycle: bank state, open-row match and data-bus
// rules. Legal commands update the banks and the bus history; illegal ones
// raise cmd_err combinationally and change nothing.
// Assumes NUM_BANKS >= 2, ROWS >= 2, T_ACT, T_PRE, RD_LAT >= 2.
module bank_timing_tracker #(
    parameter int NUM_BANKS = 4,
    parameter int ROWS      = 4096,
    parameter int T_ACT     = 3,
    parameter int T_PRE     = 3,
    parameter int RD_LAT    = 3,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int ROW_W    = $clog2(ROWS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cmd_valid,
    input  logic [2:0]                 cmd_op,
    input  logic [BANK_W-1:0]          cmd_bank,
    input  logic [ROW_W-1:0]           cmd_row,
    output logic [NUM_BANKS-1:0]       act_rdy,
    output logic [NUM_BANKS-1:0]       pre_rdy,
    output logic [NUM_BANKS-1:0]       col_rdy,
    output logic [NUM_BANKS*ROW_W-1:0] open_row,
    output logic                       wr_bus_ok,
    output logic                       cmd_err
);
    import btt_pkg::*;

    op_e              op;
    logic             bank_ok;
    logic             tgt_closed;
    logic             tgt_open;
    logic             row_hit;
    logic             legal;
    logic             accept;
    logic             op_col;
    logic             op_rd;
    logic             op_ap;
    logic [NUM_BANKS-1:0] closed_v;
    logic [NUM_BANKS-1:0] open_v;
    logic [ROW_W-1:0] row_arr [NUM_BANKS];

    // Decode the op code and look up the addressed bank.
    always_comb begin
        op         = op_e'(cmd_op);
        bank_ok    = ({1'b0, cmd_bank} < (BANK_W + 1)'(NUM_BANKS));
        tgt_closed = bank_ok && closed_v[cmd_bank];
        tgt_open   = bank_ok && open_v[cmd_bank];
        row_hit    = bank_ok && (row_arr[cmd_bank] == cmd_row);
        op_col     = (op == OP_RD) || (op == OP_WR) || (op == OP_RDA) || (op == OP_WRA);
        op_rd      = (op == OP_RD) || (op == OP_RDA);
        op_ap      = (op == OP_RDA) || (op == OP_WRA);
    end

    // Judge the presented command against bank state and bus rules.
    always_comb begin
        case (op)
            OP_NOP:         legal = 1'b1;
            OP_ACT:         legal = tgt_closed;
            OP_PRE:         legal = tgt_open;
            OP_RD, OP_RDA:  legal = tgt_open && row_hit;
            OP_WR, OP_WRA:  legal = tgt_open && row_hit && wr_bus_ok;
            default:        legal = 1'b0;
        endcase
        accept  = cmd_valid && legal;
        cmd_err = cmd_valid && !legal;
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic bank_sel;
        assign bank_sel = accept && (cmd_bank == BANK_W'(b));

        btt_bank #(
            .ROW_W (ROW_W),
            .T_ACT (T_ACT),
            .T_PRE (T_PRE)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .act_go    (bank_sel && (op == OP_ACT)),
            .pre_go    (bank_sel && (op == OP_PRE)),
            .col_go    (bank_sel && op_col),
            .col_ap    (op_ap),
            .row_in    (cmd_row),
            .is_closed (closed_v[b]),
            .is_open   (open_v[b]),
            .row_q     (row_arr[b])
        );

        assign act_rdy[b] = closed_v[b];
        assign pre_rdy[b] = open_v[b];
        assign col_rdy[b] = open_v[b];
        assign open_row[b*ROW_W +: ROW_W] = row_arr[b];
    end

    btt_dq_window #(
        .RD_LAT (RD_LAT)
    ) u_dq (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_go   (accept && op_rd),
        .wr_free (wr_bus_ok)
    );

    assert_err_keeps_rows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |=> $stable(open_row));
    assert_err_keeps_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |=> ((pre_rdy & ~$past(pre_rdy) & $past(act_rdy)) == '0));
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |-> !cmd_err);
    assert_idle_rows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> $stable(open_row));

endmodule

// File: tb/sim_bank_timing_tracker.sv
// Bench for bank_timing_tracker: a behavioural model with integer cycle
// stamps per bank and a queue of read issue cycles, compared every clock.
module sim_bank_timing_tracker;

    localparam int NB = 4;
    localparam int RW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = 3'd0;
    logic [1:0]    cmd_bank = 2'd0;
    logic [RW-1:0] cmd_row = '0;
    logic [NB-1:0] act_rdy, pre_rdy, col_rdy;
    logic [NB*RW-1:0] open_row;
    logic          wr_bus_ok, cmd_err;

    always #10 clk = ~clk;

    bank_timing_tracker #(.NUM_BANKS(NB), .ROWS(16)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_bank(cmd_bank), .cmd_row(cmd_row), .act_rdy(act_rdy),
        .pre_rdy(pre_rdy), .col_rdy(col_rdy), .open_row(open_row),
        .wr_bus_ok(wr_bus_ok), .cmd_err(cmd_err)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit m_open [NB];
    int m_avail [NB];
    int m_row [NB];
    int rd_q [$];

    function automatic bit m_closed(int b);
        return !m_open[b] && (cyc >= m_avail[b]);
    endfunction

    function automatic bit m_active(int b);
        return m_open[b] && (cyc >= m_avail[b]);
    endfunction

    function automatic bit m_wr_free();
        foreach (rd_q[i]) begin
            if ((cyc - rd_q[i]) >= 2 && (cyc - rd_q[i]) <= 4) return 1'b0;
        end
        return 1'b1;
    endfunction

    function automatic bit m_legal(int op, int b, int r);
        case (op)
            0: return 1'b1;
            1: return m_closed(b);
            2: return m_active(b);
            3, 5: return m_active(b) && (m_row[b] == r);
            4, 6: return m_active(b) && (m_row[b] == r) && m_wr_free();
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(bit ok, string tag, string what, int got, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s cycle %0d got %0h expected %0h", tag, what, cyc, got, exp);
        end
    endtask

    // Present one command, compare every output, then advance the model.
    task automatic step(bit v, int op, int b, int r, string tag);
        bit lg;
        int e_act, e_pre, e_row;
        @(negedge clk);
        cmd_valid = v;
        cmd_op    = 3'(op);
        cmd_bank  = 2'(b);
        cmd_row   = RW'(r);
        #5;
        e_act = 0; e_pre = 0; e_row = 0;
        for (int i = 0; i < NB; i++) begin
            e_act |= int'(m_closed(i)) << i;
            e_pre |= int'(m_active(i)) << i;
            e_row |= (m_row[i] & 32'hF) << (i * RW);
        end
        lg = m_legal(op, b, r);
        check(act_rdy == NB'(e_act), tag, "act_rdy", int'(act_rdy), e_act);
        check(pre_rdy == NB'(e_pre), tag, "pre_rdy", int'(pre_rdy), e_pre);
        check(col_rdy == NB'(e_pre), tag, "col_rdy", int'(col_rdy), e_pre);
        check(open_row == (NB*RW)'(e_row), tag, "open_row", int'(open_row), e_row);
        check(wr_bus_ok == m_wr_free(), tag, "wr_bus_ok", int'(wr_bus_ok), int'(m_wr_free()));
        check(cmd_err == (v && !lg), tag, "cmd_err", int'(cmd_err), int'(v && !lg));
        @(posedge clk);
        if (v && lg) begin
            case (op)
                1: begin m_open[b] = 1'b1; m_row[b] = r; m_avail[b] = cyc + 3; end
                2: begin m_open[b] = 1'b0; m_avail[b] = cyc + 3; end
                5, 6: begin m_open[b] = 1'b0; m_avail[b] = cyc + 4; end
                default: ;
            endcase
            if (op == 3 || op == 5) rd_q.push_back(cyc);
        end
        while (rd_q.size() > 0 && (cyc - rd_q[0]) > 8) void'(rd_q.pop_front());
        cyc++;
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) step(1'b0, 0, 0, 0, tag);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        finish_run();
    end

    initial begin
        bit [15:0] lfsr;
        for (int i = 0; i < NB; i++) begin m_open[i] = 0; m_avail[i] = 0; m_row[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        cyc = 0;

        step(1'b0, 0, 0, 0, "R1");                 // reset state
        step(1'b1, 1, 0, 5, "R2");                 // activate bank0 row5
        step(1'b1, 3, 0, 5, "R2");                 // read while opening: error
        step(1'b1, 1, 1, 7, "R4");                 // other bank legal while bank0 busy
        step(1'b1, 3, 0, 5, "R2");                 // c+3 after activate: legal read
        step(1'b1, 3, 0, 5, "R5");                 // back-to-back read
        step(1'b1, 3, 0, 6, "R5");                 // row miss: error
        step(1'b1, 4, 1, 7, "R6");                 // write 2 after read: error
        step(1'b1, 4, 1, 7, "R6");                 // 3 after read: error
        step(1'b1, 4, 1, 7, "R6");                 // 4 after read: error
        step(1'b1, 4, 1, 7, "R6");                 // 5 after read: legal
        step(1'b1, 3, 1, 7, "R6");                 // read right after write: legal
        step(1'b1, 2, 0, 0, "R3");                 // precharge bank0
        step(1'b1, 1, 0, 9, "R3");                 // activate while closing: error
        step(1'b1, 2, 0, 0, "R3");                 // precharge while closing: error
        step(1'b1, 1, 0, 9, "R3");                 // c+3 after precharge: legal
        step(1'b1, 2, 2, 0, "R3");                 // precharge closed bank: error
        step(1'b1, 2, 0, 0, "R3");                 // precharge while opening: error
        idle(2, "R2");
        step(1'b1, 5, 1, 7, "R7");                 // read with auto-precharge
        step(1'b1, 3, 1, 7, "R7");                 // bank closing: error
        step(1'b1, 1, 1, 3, "R7");                 // c+2: error
        step(1'b1, 1, 1, 3, "R7");                 // c+3: error
        step(1'b1, 1, 1, 3, "R7");                 // c+4: legal
        step(1'b1, 7, 0, 9, "R9");                 // reserved op: error
        step(1'b0, 1, 2, 4, "R9");                 // invalid activate ignored
        step(1'b0, 2, 0, 9, "R9");                 // invalid precharge ignored
        step(1'b1, 0, 3, 1, "R9");                 // nop legal
        step(1'b1, 6, 0, 9, "R7");                 // write with auto-precharge
        idle(4, "R7");

        lfsr = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            int op, b, r;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            op = int'(lfsr[2:0]);
            b  = int'(lfsr[4:3]);
            r  = int'(lfsr[6:5]);
            step(lfsr[9] | lfsr[8], op, b, r, "R8");
        end
        finish_run();
    end

endmodule